// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer controlled through four 32-bit registers on a simple synchronous register port. Software keeps the system alive by writing a two-word refresh key into the counter register. To change the timeout, window or control settings, software must first write a different two-word unlock key. A counter advances on one of four tick-enable inputs, chosen in the control register. If the counter reaches the programmed timeout, the block raises a sticky reset request and sets a timeout flag. A key sequence that breaks protocol also raises the reset request at once, and so does a refresh that arrives too early while a refresh window is set.

Key handling is a small state machine. `KS_IDLE` waits for a first key word. `KS_RFSH_HALF` holds a pending refresh and `KS_ULK_HALF` holds a pending unlock. `KS_OPEN` accepts configuration writes. `KS_APPLY` moves the staged settings into force.

The transitions are named as follows:
- *refresh-start* (IDLE→RFSH_HALF).
- *unlock-start* (IDLE→ULK_HALF).
- *refresh-done* and *refresh-error* (RFSH_HALF→IDLE).
- *unlock-done* (ULK_HALF→OPEN) and *unlock-error* (ULK_HALF→IDLE).
- *abort* (either half state→IDLE on a write to any other register).
- *commit* (OPEN→APPLY on a control write).
- *relock* (OPEN→IDLE when the open window expires).
- *applied* (APPLY→IDLE).

Top module: `keyed_wdog`

## Requirements
- R1: After reset the registers read as follows: control/status (word 0) 0x0000_0020, counter (word 1) 0, timeout (word 2) 0x0000_FFFF, window (word 3) 0. Both `rst_req` and `tmo_irq` are 0.
- R2: The control/status fields are: bit 7 count enable, bit 5 update-allowed, bits 9:8 tick select. The counter increases by one on each clock edge where the count enable bit is 1, bit `tick_en[sel]` is 1, and the counter is below the timeout. Other `tick_en` bits have no effect.
- R3: In the cycle after the counter equals the timeout with counting enabled, the timeout flag (bit 14), `tmo_irq` and `rst_req` become 1. The counter then holds at the timeout value.
- R4: Writing 0xA602 to the counter register and then 0xB480 as the next register write clears the counter to 0 at that second write.
- R5: Writing 0xC520 and then 0xD928 to the counter register makes the unlocked bit (bit 11) read 1. Writes to control, timeout and window are ignored while the block is locked.
- R6: The first unlock word clears bits 10 and 11. A control write while unlocked commits the staged settings. From the second clock edge after that write, the new settings are in force, bit 10 reads 1 and bit 11 reads 0. Bit 10 is still 0 after the first edge.
- R7: Writing control/status with bit 14 = 1 clears the timeout flag, whether or not the block is locked. Writing 0 to bit 14 leaves the flag unchanged.
- R8: A write to any other register between the two words of a key cancels the pending key, without a reset request.
- R9: Each of these raises `rst_req` on the next clock edge: a counter write of 0xB480 or 0xD928 with no first word pending, or any counter write other than the expected second word while a first word is pending. `rst_req` then stays 1 until reset.
- R10: If no control write arrives, the block relocks 128 clock edges after the unlock completes. Bit 11 still reads 1 after 127 edges.
- R11: If update-allowed (bit 5) was 0 in the last committed control, both unlock words have no effect and raise no reset request.
- R12: If the window is nonzero, a completed refresh while the counter is below the window raises `rst_req`. A refresh at or above the window, or any refresh with the window at 0, does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 control/status, 1 counter, 2 timeout, 3 window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_en | input | 4 | Tick enables, one per selectable source |
| rst_req | output | 1 | Sticky reset request |
| tmo_irq | output | 1 | Timeout flag |

## Verification
A wrong key state shows at the ports on the very next edge. A stray second word either raises `rst_req` or fails to clear the counter, and the unlocked bit flips at the wrong write. Settings staged wrongly in the configuration copy first appear two edges after the commit write, as wrong control or timeout read-back and a counter that advances on the wrong tick input. A bad open-window timer shows as bit 11 dropping too early or too late around edge 128. A wrong counter limit shows as the timeout flag rising a cycle early or late, or as the counter moving past the timeout.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned SRC_W  = 2;
    localparam int unsigned N_TICK = 1 << SRC_W;

    localparam logic [REG_W-1:0] KEY_RFSH_A = 32'h0000_A602;
    localparam logic [REG_W-1:0] KEY_RFSH_B = 32'h0000_B480;
    localparam logic [REG_W-1:0] KEY_ULK_A  = 32'h0000_C520;
    localparam logic [REG_W-1:0] KEY_ULK_B  = 32'h0000_D928;

    localparam int unsigned POS_UPD  = 5;
    localparam int unsigned POS_EN   = 7;
    localparam int unsigned POS_SRC  = 8;
    localparam int unsigned POS_DONE = 10;
    localparam int unsigned POS_ULK  = 11;
    localparam int unsigned POS_FLAG = 14;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_CNT  = 2'd1,
        ADR_TOV  = 2'd2,
        ADR_WIN  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_RFSH_HALF,
        KS_ULK_HALF,
        KS_OPEN,
        KS_APPLY
    } key_state_e;

    typedef struct packed {
        logic             en;
        logic             upd;
        logic [SRC_W-1:0] src;
    } ctrl_t;
endpackage

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
    import wdk_pkg::*;
#(
    parameter int unsigned ULK_WINDOW = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_other,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] word,
    input  logic             upd_allowed,
    output key_state_e       state,
    output logic             refresh_ok,
    output logic             seq_err,
    output logic             unlock_start,
    output logic             open_o,
    output logic             apply_o
);
    localparam int unsigned TMR_W = (ULK_WINDOW > 2) ? $clog2(ULK_WINDOW) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ULK_WINDOW - 1);

    key_state_e       nxt;
    logic [TMR_W-1:0] timer;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= nxt;
    end

    // open-window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 timer <= '0;
        else if (state != KS_OPEN)  timer <= '0;
        else                        timer <= timer + 1'b1;
    end

    // next state and outputs
    always_comb begin
        nxt          = state;
        refresh_ok   = 1'b0;
        seq_err      = 1'b0;
        unlock_start = 1'b0;
        unique case (state)
            KS_IDLE: begin
                if (wr_cnt) begin
                    if (word == KEY_RFSH_A) begin
                        nxt = KS_RFSH_HALF;                 // refresh-start
                    end else if (word == KEY_ULK_A && upd_allowed) begin
                        nxt          = KS_ULK_HALF;         // unlock-start
                        unlock_start = 1'b1;
                    end else if (word == KEY_RFSH_B ||
                                 (word == KEY_ULK_B && upd_allowed)) begin
                        seq_err = 1'b1;
                    end
                end
            end
            KS_RFSH_HALF: begin
                if (wr_cnt) begin
                    nxt = KS_IDLE;
                    if (word == KEY_RFSH_B) refresh_ok = 1'b1;   // refresh-done
                    else                    seq_err    = 1'b1;   // refresh-error
                end else if (wr_other) begin
                    nxt = KS_IDLE;                               // abort
                end
            end
            KS_ULK_HALF: begin
                if (wr_cnt) begin
                    if (word == KEY_ULK_B) begin
                        nxt = KS_OPEN;                           // unlock-done
                    end else begin
                        nxt     = KS_IDLE;                       // unlock-error
                        seq_err = 1'b1;
                    end
                end else if (wr_other) begin
                    nxt = KS_IDLE;                               // abort
                end
            end
            KS_OPEN: begin
                if (wr_ctrl)                nxt = KS_APPLY;      // commit
                else if (timer == TMR_LAST) nxt = KS_IDLE;       // relock
            end
            KS_APPLY: nxt = KS_IDLE;                             // applied
            default:  nxt = KS_IDLE;
        endcase
    end

    assign open_o  = (state == KS_OPEN);
    assign apply_o = (state == KS_APPLY);
endmodule

// File: rtl/wdk_cfg.sv
module wdk_cfg
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             apply_i,
    input  logic             ulk_start_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_tov_i,
    input  logic             wr_win_i,
    input  ctrl_t            ctrl_in,
    input  logic [CNT_W-1:0] val_in,
    output ctrl_t            act_ctrl,
    output logic [CNT_W-1:0] act_tov,
    output logic [CNT_W-1:0] act_win,
    output logic             done_o
);
    localparam ctrl_t CTRL_RST = '{en: 1'b0, upd: 1'b1, src: '0};

    ctrl_t            sh_ctrl;
    logic [CNT_W-1:0] sh_tov;
    logic [CNT_W-1:0] sh_win;

    // staged copy, written only while open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ctrl <= CTRL_RST;
            sh_tov  <= '1;
            sh_win  <= '0;
        end else if (ulk_start_i) begin
            sh_ctrl <= act_ctrl;
            sh_tov  <= act_tov;
            sh_win  <= act_win;
        end else if (open_i) begin
            if (wr_ctrl_i) sh_ctrl <= ctrl_in;
            if (wr_tov_i)  sh_tov  <= val_in;
            if (wr_win_i)  sh_win  <= val_in;
        end
    end

    // settings in force
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ctrl <= CTRL_RST;
            act_tov  <= '1;
            act_win  <= '0;
        end else if (apply_i) begin
            act_ctrl <= sh_ctrl;
            act_tov  <= sh_tov;
            act_win  <= sh_win;
        end
    end

    // reconfiguration-complete handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           done_o <= 1'b0;
        else if (ulk_start_i) done_o <= 1'b0;
        else if (apply_i)     done_o <= 1'b1;
    end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SRC_W-1:0]  src,
    input  logic [N_TICK-1:0] tick_en,
    input  logic [CNT_W-1:0]  tov,
    input  logic              clear,
    output logic [CNT_W-1:0]  cnt,
    output logic              at_limit
);
    logic [N_TICK-1:0] src_hot;
    logic              tick;

    for (genvar g = 0; g < N_TICK; g++) begin : g_src
        assign src_hot[g] = (src == SRC_W'(g)) && tick_en[g];
    end
    assign tick = |src_hot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (clear)                      cnt <= '0;
        else if (en && tick && (cnt < tov))  cnt <= cnt + 1'b1;
    end

    assign at_limit = en && (cnt >= tov);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned ULK_WINDOW = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [N_TICK-1:0] tick_en,
    output logic              rst_req,
    output logic              tmo_irq
);
    reg_sel_e         sel;
    logic             wr_cnt, wr_ctrl, wr_tov, wr_win, wr_other;
    key_state_e       kstate;
    logic             refresh_ok, seq_err, unlock_start, open_s, apply_s;
    ctrl_t            act_ctrl, ctrl_in;
    logic [CNT_W-1:0] act_tov, act_win, cnt;
    logic             cfg_done, at_limit, cnt_en, unlocked, win_viol, flag;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_cnt   = reg_we && (sel == ADR_CNT);
    assign wr_ctrl  = reg_we && (sel == ADR_CTRL);
    assign wr_tov   = reg_we && (sel == ADR_TOV);
    assign wr_win   = reg_we && (sel == ADR_WIN);
    assign wr_other = reg_we && (sel != ADR_CNT);

    assign ctrl_in.en  = reg_wdata[POS_EN];
    assign ctrl_in.upd = reg_wdata[POS_UPD];
    assign ctrl_in.src = reg_wdata[POS_SRC +: SRC_W];

    wdk_keyfsm #(.ULK_WINDOW(ULK_WINDOW)) u_keyfsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cnt       (wr_cnt),
        .wr_other     (wr_other),
        .wr_ctrl      (wr_ctrl),
        .word         (reg_wdata),
        .upd_allowed  (act_ctrl.upd),
        .state        (kstate),
        .refresh_ok   (refresh_ok),
        .seq_err      (seq_err),
        .unlock_start (unlock_start),
        .open_o       (open_s),
        .apply_o      (apply_s)
    );

    wdk_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (open_s),
        .apply_i     (apply_s),
        .ulk_start_i (unlock_start),
        .wr_ctrl_i   (wr_ctrl),
        .wr_tov_i    (wr_tov),
        .wr_win_i    (wr_win),
        .ctrl_in     (ctrl_in),
        .val_in      (reg_wdata[CNT_W-1:0]),
        .act_ctrl    (act_ctrl),
        .act_tov     (act_tov),
        .act_win     (act_win),
        .done_o      (cfg_done)
    );

    assign cnt_en = act_ctrl.en;

    wdk_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .src      (act_ctrl.src),
        .tick_en  (tick_en),
        .tov      (act_tov),
        .clear    (refresh_ok),
        .cnt      (cnt),
        .at_limit (at_limit)
    );

    assign unlocked = open_s;
    assign win_viol = refresh_ok && (act_win != '0) && (cnt < act_win);

    // timeout flag: set wins over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (at_limit)                       flag <= 1'b1;
        else if (wr_ctrl && reg_wdata[POS_FLAG]) flag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= rst_req | at_limit | seq_err | win_viol;
    end

    assign tmo_irq = flag;

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            ADR_CTRL: begin
                reg_rdata[POS_UPD]             = act_ctrl.upd;
                reg_rdata[POS_EN]              = act_ctrl.en;
                reg_rdata[POS_SRC +: SRC_W]    = act_ctrl.src;
                reg_rdata[POS_DONE]            = cfg_done;
                reg_rdata[POS_ULK]             = unlocked;
                reg_rdata[POS_FLAG]            = flag;
            end
            ADR_CNT: reg_rdata[CNT_W-1:0] = cnt;
            ADR_TOV: reg_rdata[CNT_W-1:0] = act_tov;
            ADR_WIN: reg_rdata[CNT_W-1:0] = act_win;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input key_state_e       kstate,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tov,
    input logic             cnt_en,
    input logic             cfg_done,
    input logic             unlocked,
    input logic             rst_req,
    input logic             tmo_irq
);
    logic cnt_wr;
    assign cnt_wr = reg_we && (reg_addr == ADR_CNT);

    assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && reg_wdata == KEY_RFSH_B && kstate == KS_RFSH_HALF) |=> (cnt == '0));

    assert_unlock_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(cnt_wr && reg_wdata == KEY_ULK_B));

    assert_done_cleared_by_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_done) |-> $past(cnt_wr && reg_wdata == KEY_ULK_A));

    assert_apply_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kstate == KS_APPLY) |-> $past(kstate == KS_OPEN && reg_we && reg_addr == ADR_CTRL));

    assert_flag_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> $past(cnt_en && cnt >= tov));

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && $stable(tov) && $past(cnt <= tov)) |-> (cnt <= tov));

    assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .kstate    (kstate),
    .cnt       (cnt),
    .tov       (act_tov),
    .cnt_en    (cnt_en),
    .cfg_done  (cfg_done),
    .unlocked  (unlocked),
    .rst_req   (rst_req),
    .tmo_irq   (tmo_irq)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
    localparam int WIN_LEN = 128;
    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_TOV = 2'd2, A_WIN = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tick_en = 4'b0;
    logic        rst_req, tmo_irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
        .rst_req(rst_req), .tmo_irq(tmo_irq)
    );

    function automatic logic [31:0] mk_ctrl(bit en, bit upd, logic [1:0] src);
        return (32'(en) << 7) | (32'(upd) << 5) | (32'(src) << 8);
    endfunction

    function automatic bit f_stray(logic [31:0] v);
        return (v == 32'hB480) || (v == 32'hD928);
    endfunction

    function automatic bit f_win_viol(logic [31:0] c, logic [31:0] w);
        return (w != 0) && (c < w);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        reg_we = 1'b0; tick_en = 4'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic refresh();
        wr(A_CNT, 32'hA602);
        wr(A_CNT, 32'hB480);
    endtask

    task automatic configure(logic [31:0] ctrl, logic [31:0] tov, logic [31:0] win);
        wr(A_CNT, 32'hC520);
        wr(A_CNT, 32'hD928);
        wr(A_TOV, tov);
        wr(A_WIN, win);
        wr(A_CTRL, ctrl);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset values
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h20);
        rd(A_CNT, d);  chk("R1 cnt", d, 0);
        rd(A_TOV, d);  chk("R1 tov", d, 32'hFFFF);
        rd(A_WIN, d);  chk("R1 win", d, 0);
        chk("R1 outputs", {rst_req, tmo_irq}, 0);

        // R5 locked write ignored
        wr(A_TOV, 32'h5);
        rd(A_TOV, d); chk("R5 locked tov", d, 32'hFFFF);

        // R5/R6 unlock and commit handshake
        wr(A_CNT, 32'hC520);
        rd(A_CTRL, d); chk("R6 bits cleared", d[11:10], 0);
        wr(A_CNT, 32'hD928);
        rd(A_CTRL, d); chk("R5 unlocked", d[11], 1);
        wr(A_TOV, 32'h40);
        wr(A_CTRL, mk_ctrl(1, 1, 2'd1));
        rd(A_CTRL, d); chk("R6 not yet done", d[10], 0);
        @(negedge clk);
        rd(A_CTRL, d); chk("R6 done", d[11:10], 2'b01);
        chk("R6 ctrl in force", d[9:0], 10'h1A0);
        rd(A_TOV, d); chk("R6 tov in force", d, 32'h40);

        // R2 tick select
        tick_en = 4'b1101;
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R2 unselected ticks", d, 0);
        tick_en = 4'b0010;
        rd(A_CNT, c);
        repeat (7) @(negedge clk);
        rd(A_CNT, d); chk("R2 count", d, c + 7);

        // R4 refresh
        refresh();
        rd(A_CNT, d); chk("R4 cleared", d, 0);

        // R3 timeout
        rd(A_CNT, c);
        repeat (32'h40 - c) @(negedge clk);
        rd(A_CNT, d); chk("R3 reached", d, 32'h40);
        chk("R3 flag not yet", tmo_irq, 0);
        @(negedge clk);
        rd(A_CTRL, d); chk("R3 flag bit", d[14], 1);
        chk("R3 outputs", {rst_req, tmo_irq}, 2'b11);
        repeat (3) @(negedge clk);
        rd(A_CNT, d); chk("R3 hold", d, 32'h40);

        // R7 write-one-to-clear
        tick_en = 4'b0;
        refresh();
        wr(A_CTRL, 32'h0);
        chk("R7 zero keeps flag", tmo_irq, 1);
        wr(A_CTRL, 32'h4000);
        chk("R7 flag cleared", tmo_irq, 0);
        chk("R9 sticky", rst_req, 1);

        // R9 out-of-sequence words
        do_reset(); wr(A_CNT, 32'hB480); chk("R9 stray second", rst_req, 1);
        do_reset(); wr(A_CNT, 32'hA602); wr(A_CNT, 32'h1234); chk("R9 wrong second", rst_req, 1);
        do_reset(); wr(A_CNT, 32'hC520); wr(A_CNT, 32'hA602); chk("R9 mixed keys", rst_req, 1);

        // R8 abort by another write
        do_reset();
        configure(mk_ctrl(1, 1, 2'd0), 32'hFFFF, 0);
        tick_en = 4'b0001;
        wr(A_CNT, 32'hA602);
        chk("R8 no req at first word", rst_req, 0);
        wr(A_WIN, 32'h7);
        chk("R8 no req on abort", rst_req, 0);
        tick_en = 4'b0;
        wr(A_CNT, 32'hB480);
        rd(A_CNT, d);
        chk("R8 aborted not cleared", (d != 0), 1);
        chk("R8 second word now stray", rst_req, 1);
        do_reset();
        configure(mk_ctrl(1, 1, 2'd0), 32'hFFFF, 0);
        tick_en = 4'b0001;
        wr(A_CNT, 32'hA602);
        wr(A_TOV, 32'h3);
        tick_en = 4'b0;
        refresh();
        rd(A_CNT, d); chk("R8 restart refresh", d, 0);
        chk("R8 restart no req", rst_req, 0);

        // R10 relock
        do_reset();
        wr(A_CNT, 32'hC520);
        wr(A_CNT, 32'hD928);
        repeat (WIN_LEN - 1) @(negedge clk);
        rd(A_CTRL, d); chk("R10 still open", d[11], 1);
        @(negedge clk);
        rd(A_CTRL, d); chk("R10 relocked", d[11], 0);
        wr(A_TOV, 32'h5);
        rd(A_TOV, d); chk("R10 write ignored", d, 32'hFFFF);

        // R11 update lock
        do_reset();
        configure(mk_ctrl(0, 0, 2'd2), 32'h77, 0);
        wr(A_CNT, 32'hC520);
        wr(A_CNT, 32'hD928);
        rd(A_CTRL, d); chk("R11 stays locked", d[11], 0);
        chk("R11 no req", rst_req, 0);
        wr(A_TOV, 32'h3);
        rd(A_TOV, d); chk("R11 tov kept", d, 32'h77);

        // R12 window directed
        do_reset();
        configure(mk_ctrl(1, 1, 2'd0), 32'hFFFF, 32'h20);
        tick_en = 4'b0001; repeat (5) @(negedge clk); tick_en = 4'b0;
        refresh();
        chk("R12 early refresh", rst_req, 1);
        do_reset();
        configure(mk_ctrl(1, 1, 2'd0), 32'hFFFF, 32'h20);
        tick_en = 4'b0001; repeat (48) @(negedge clk); tick_en = 4'b0;
        refresh();
        chk("R12 late refresh", rst_req, 0);

        // R9 random stray words
        for (int i = 0; i < 20; i++) begin
            logic [31:0] v;
            int sel = $urandom % 4;
            if (sel == 0)      v = 32'hB480;
            else if (sel == 1) v = 32'hD928;
            else begin
                v = {16'h0, 16'($urandom)};
                if (v == 32'hA602 || v == 32'hC520) v = 32'h0;
            end
            do_reset();
            wr(A_CNT, v);
            chk("R9 random word", rst_req, f_stray(v));
        end

        // R12/R4 random window refresh
        for (int i = 0; i < 20; i++) begin
            logic [31:0] w;
            w = ($urandom % 3 == 0) ? 0 : ($urandom % 64);
            do_reset();
            configure(mk_ctrl(1, 1, 2'd3), 32'hFFFF, w);
            tick_en = 4'b1000;
            repeat ($urandom % 64) @(negedge clk);
            tick_en = 4'b0;
            rd(A_CNT, c);
            refresh();
            chk("R12 random window", rst_req, f_win_viol(c, w));
            rd(A_CNT, d); chk("R4 random clear", d, 0);
        end

        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule